// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Stalling Writes

This block is a serial transmitter and receiver that sits on a simple word-addressed processor bus. It has one pin out and one pin in and no queue in either direction. Software sets the bit time by writing a divider register, turns the port on through an enable register, sends a byte by writing the data register and collects a received byte by reading the same register.

The transmitter holds exactly one byte. If software writes a new byte while a frame is still on the line, the bus handshake stalls: `bus_ready` stays low until the frame's stop bit has been sent, and then the write is taken and the next frame starts. No status flag has to be polled. The receiver keeps one byte. A read of the data register returns that byte and empties the buffer. If the buffer is empty, the read returns all ones.

Frames are 8N1: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line idles high. Each bit lasts the divider value in core clock cycles.

Top module: `uart_mm`

## Requirements
- R1: After reset, the divider reads 1, the enable register reads 0, a data-register read returns 0xFFFFFFFF and `tx_o` is high.
- R2: Only address bits [3:2] are decoded. Index 0 (byte offset 0x0) is the 32-bit read/write divider. Index 1 (0x4) is the data register. Index 2 (0x8) is the enable register: its low 8 bits can be written and its upper 24 bits read as zero. Index 3 reads zero and ignores writes.
- R3: With the port enabled and the transmitter idle, a data write completes in the cycle it is presented. `tx_o` goes low in the next cycle. The frame is then a start bit of 0, the 8 data bits LSB first and a stop bit of 1, and each bit lasts D cycles, where D is the effective divider.
- R4: A data write presented while a frame is in progress keeps `bus_ready` low until D*10 cycles after the earlier write was accepted. It is accepted one cycle later, and its frame follows at once.
- R5: A divider value of 0 or 1 gives a bit time of 2 cycles. The register still reads back the value that was written.
- R6: A data read while a byte is buffered returns {24'h0, byte} and empties the buffer, so the next read returns 0xFFFFFFFF.
- R7: A data read with no buffered byte returns 0xFFFFFFFF.
- R8: While the enable register is zero, a data write completes at once but `tx_o` stays high, and frames arriving on `rx_i` are not buffered.
- R9: The receiver confirms a start bit half a bit time after the falling edge. A low pulse shorter than that is dropped, and data bits are sampled at mid-bit.
- R10: A byte that is received while an earlier byte is still unread replaces it.
- R11: Accesses to the divider and enable registers complete in the cycle they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (bits [3:2] decoded) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Request completes on this clock edge |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |

## Verification
Register accesses are checked in the cycle they are presented. The start bit is expected on `tx_o` at the first falling clock edge after the accepting edge. Each transmitted bit k is sampled at cycle k*D + D/2 counted from that edge, and the idle level is checked at cycle 10*D. A write that meets a busy transmitter is counted in stall cycles and must total exactly 10*D - 1 when it is issued one cycle after the earlier write. Received bytes are read only after the whole frame has been driven plus four cycles. That covers the two-stage input synchroniser and the half-bit offset of the sampling point.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 32;
    localparam logic [WORD_W-1:0] DIV_AT_RESET = 32'd1;
    localparam logic [WORD_W-1:0] EMPTY_WORD   = {WORD_W{1'b1}};
    localparam logic [CNT_W-1:0]  DIV_FLOOR    = 32'd2;

    typedef enum logic [1:0] {
        SEL_DIV  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_EN   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_START,
        RXS_BITS,
        RXS_STOP
    } rx_state_e;

    typedef struct packed {
        logic              full;
        logic [BYTE_W-1:0] data;
    } rx_buf_t;

    function automatic logic [CNT_W-1:0] bit_time(input logic [CNT_W-1:0] raw);
        return (raw < DIV_FLOOR) ? DIV_FLOOR : raw;
    endfunction

endpackage

// File: rtl/uart_mm_tx.sv
module uart_mm_tx
    import uart_mm_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int DIV_W  = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DIV_W-1:0]  bit_len,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              tx_o
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shift_q;
    logic [IDX_W-1:0]   idx_q;
    logic [DIV_W-1:0]   cnt_q;
    logic               busy_q;
    logic               bit_end;

    assign bit_end = (cnt_q >= bit_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            shift_q <= '1;
            idx_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
        end else if (load && !busy_q) begin
            shift_q <= {1'b1, load_data, 1'b0};
            idx_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b1;
        end else if (busy_q) begin
            if (bit_end) begin
                cnt_q   <= '0;
                shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
                if (idx_q == LAST_IDX) busy_q <= 1'b0;
                else                   idx_q  <= idx_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign tx_o = busy_q ? shift_q[0] : 1'b1;

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !tx_o); // R3

endmodule

// File: rtl/uart_mm_rx.sv
module uart_mm_rx
    import uart_mm_pkg::*;
#(
    parameter int DATA_W      = BYTE_W,
    parameter int DIV_W       = CNT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DIV_W-1:0]  bit_len,
    input  logic              rx_i,
    output logic              done,
    output logic [DATA_W-1:0] data
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    logic [SYNC_STAGES:0] sync_q;
    logic                 line;
    logic                 line_prev;
    rx_state_e            state_q;
    logic [DIV_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_W-1:0]    shift_q;
    logic                 done_q;
    logic [DIV_W-1:0]     half_len;

    generate
        for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) sync_q[s] <= 1'b1;
                else     sync_q[s] <= (s == 0) ? rx_i : sync_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign line      = sync_q[SYNC_STAGES-1];
    assign line_prev = sync_q[SYNC_STAGES];
    assign half_len  = bit_len >> 1;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= RXS_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                RXS_IDLE: begin
                    cnt_q <= '0;
                    if (line_prev && !line) state_q <= RXS_START;
                end
                RXS_START: begin
                    if (cnt_q >= half_len - 1'b1) begin
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        state_q <= line ? RXS_IDLE : RXS_BITS;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RXS_BITS: begin
                    if (cnt_q >= bit_len - 1'b1) begin
                        cnt_q   <= '0;
                        shift_q <= {line, shift_q[DATA_W-1:1]};
                        if (idx_q == LAST_IDX) state_q <= RXS_STOP;
                        else                   idx_q   <= idx_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RXS_STOP: begin
                    if (cnt_q >= bit_len - 1'b1) begin
                        cnt_q   <= '0;
                        done_q  <= line;
                        state_q <= RXS_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= RXS_IDLE;
            endcase
        end
    end

    assign done = done_q;
    assign data = shift_q;

    AST_ONE_BYTE_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R9

endmodule

// File: rtl/uart_mm.sv
module uart_mm
    import uart_mm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    input  logic              rx_i,
    output logic              tx_o
);
    logic [WORD_W-1:0] div_q;
    logic [BYTE_W-1:0] en_q;
    rx_buf_t           rxbuf_q;
    reg_sel_e          sel;
    logic              enabled;
    logic [CNT_W-1:0]  bit_len;
    logic              tx_busy;
    logic              tx_load;
    logic              rx_done;
    logic [BYTE_W-1:0] rx_data;
    logic              wr_acc;
    logic              rd_data_acc;

    assign sel      = reg_sel_e'(bus_addr[3:2]);
    assign enabled  = |en_q;
    assign bit_len  = bit_time(div_q);

    always_comb begin
        bus_ready = 1'b1;
        if (bus_we && sel == SEL_DATA) bus_ready = !tx_busy;
    end

    assign wr_acc      = bus_valid && bus_we && bus_ready;
    assign rd_data_acc = bus_valid && !bus_we && sel == SEL_DATA;
    assign tx_load     = wr_acc && sel == SEL_DATA && enabled;

    always_comb begin
        unique case (sel)
            SEL_DIV:  bus_rdata = div_q;
            SEL_DATA: bus_rdata = rxbuf_q.full ? {{(WORD_W-BYTE_W){1'b0}}, rxbuf_q.data}
                                               : EMPTY_WORD;
            SEL_EN:   bus_rdata = {{(WORD_W-BYTE_W){1'b0}}, en_q};
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= DIV_AT_RESET;
            en_q  <= '0;
        end else if (wr_acc) begin
            if (sel == SEL_DIV) div_q <= bus_wdata;
            if (sel == SEL_EN)  en_q  <= bus_wdata[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxbuf_q <= '0;
        end else if (rx_done) begin
            rxbuf_q.full <= 1'b1;
            rxbuf_q.data <= rx_data;
        end else if (rd_data_acc) begin
            rxbuf_q.full <= 1'b0;
        end
    end

    uart_mm_tx #(.DATA_W(BYTE_W), .DIV_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .en        (enabled),
        .bit_len   (bit_len),
        .load      (tx_load),
        .load_data (bus_wdata[BYTE_W-1:0]),
        .busy      (tx_busy),
        .tx_o      (tx_o)
    );

    uart_mm_rx #(.DATA_W(BYTE_W), .DIV_W(CNT_W), .SYNC_STAGES(2)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .en      (enabled),
        .bit_len (bit_len),
        .rx_i    (rx_i),
        .done    (rx_done),
        .data    (rx_data)
    );

    AST_WRITE_STARTS_FRAME: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> (tx_busy && !tx_o)); // R3

    AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && sel == SEL_DATA && !bus_ready) |=> $past(tx_busy)); // R4

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (rd_data_acc && !rx_done) |=> !rxbuf_q.full); // R6

    AST_OFF_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !enabled |=> tx_o); // R8

    AST_REG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && sel != SEL_DATA) |-> bus_ready); // R11

endmodule

// File: tb/uart_mm_tb_top.sv
`timescale 1ns/1ps
module uart_mm_tb_top;

    localparam logic [7:0] A_DIV  = 8'h00;
    localparam logic [7:0] A_DATA = 8'h04;
    localparam logic [7:0] A_EN   = 8'h08;
    localparam logic [7:0] A_GAP  = 8'h0C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        rx_i = 1'b1;
    logic        tx_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    uart_mm #(.ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .rx_i(rx_i), .tx_o(tx_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic int eff(input int raw);
        return (raw < 2) ? 2 : raw;
    endfunction

    function automatic logic [9:0] frame_of(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

    // Returns at the first falling edge after the accepting edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int stalls);
        stalls = 0;
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        forever begin
            #1;
            if (bus_ready) break;
            stalls++;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output bit rdy);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata; rdy = bus_ready;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // Call at the falling edge right after the accepting edge.
    task automatic check_frame(input logic [7:0] b, input int d, input string req);
        logic [9:0] got;
        int idx = 0;
        chk(tx_o == 1'b0, req, {31'h0, tx_o}, 32'h0);
        for (int k = 0; k < 10; k++) begin
            while (idx < k*d + d/2) begin @(negedge clk); idx++; end
            got[k] = tx_o;
        end
        chk(got == frame_of(b), req, {22'h0, got}, {22'h0, frame_of(b)});
        while (idx < 10*d) begin @(negedge clk); idx++; end
        chk(tx_o == 1'b1, req, {31'h0, tx_o}, 32'h1);
    endtask

    task automatic send_rx(input logic [7:0] b, input int d);
        logic [9:0] f = frame_of(b);
        @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            rx_i = f[k];
            repeat (d) @(negedge clk);
        end
        rx_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(8ns * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        bit rdy;
        int st, st2, d;
        logic [7:0] b, b2;
        void'($urandom(32'd1357));

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tx_o == 1'b1, "R1 tx idle", {31'h0, tx_o}, 32'h1);
        rd(A_DIV, rv, rdy);  chk(rv == 32'h1, "R1 divider", rv, 32'h1);
        chk(rdy, "R11 divider read ready", {31'h0, rdy}, 32'h1);
        rd(A_EN, rv, rdy);   chk(rv == 32'h0, "R1 enable", rv, 32'h0);
        rd(A_DATA, rv, rdy); chk(rv == 32'hFFFFFFFF, "R1 data empty", rv, 32'hFFFFFFFF);

        // R8 disabled: write accepted, no transmit, no receive
        wr(A_DIV, 32'd8, st);
        wr(A_DATA, 32'hA5, st);
        chk(st == 0, "R8 write while off", st, 0);
        begin
            bit seen_low = 1'b0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (!tx_o) seen_low = 1'b1;
            end
            chk(!seen_low, "R8 tx stays high", {31'h0, seen_low}, 32'h0);
        end
        send_rx(8'h3C, 8);
        rd(A_DATA, rv, rdy); chk(rv == 32'hFFFFFFFF, "R8 rx ignored", rv, 32'hFFFFFFFF);

        // R2 / R11 register access
        wr(A_EN, 32'hFFFFFF01, st);
        chk(st == 0, "R11 enable write one cycle", st, 0);
        rd(A_EN, rv, rdy); chk(rv == 32'h01, "R2 enable upper bits zero", rv, 32'h01);
        wr(A_DIV, 32'h0001_2345, st);
        chk(st == 0, "R11 divider write one cycle", st, 0);
        rd(A_DIV, rv, rdy); chk(rv == 32'h0001_2345, "R2 divider 32-bit", rv, 32'h0001_2345);
        wr(A_GAP, 32'h1234, st);
        rd(A_GAP, rv, rdy); chk(rv == 32'h0, "R2 unused index", rv, 32'h0);

        // R3 directed frame
        wr(A_DIV, 32'd8, st);
        wr(A_DATA, 32'hFFFF_FF55, st);
        chk(st == 0, "R3 idle write no stall", st, 0);
        check_frame(8'h55, 8, "R3 frame 0x55");

        // R4 back-to-back stall
        wr(A_DIV, 32'd4, st);
        wr(A_DATA, 32'h81, st);
        fork
            check_frame(8'h81, 4, "R4 first frame");
            wr(A_DATA, 32'h7E, st2);
        join
        chk(st2 == 10*4 - 1, "R4 stall cycles", st2, 10*4 - 1);
        check_frame(8'h7E, 4, "R4 second frame");

        // R5 divider floor
        wr(A_DIV, 32'd0, st);
        rd(A_DIV, rv, rdy); chk(rv == 32'd0, "R5 raw readback", rv, 32'd0);
        wr(A_DATA, 32'h0F, st);
        check_frame(8'h0F, 2, "R5 div 0 gives 2");
        wr(A_DIV, 32'd1, st);
        wr(A_DATA, 32'hC6, st);
        check_frame(8'hC6, 2, "R5 div 1 gives 2");

        // R3 random frames
        for (int n = 0; n < 6; n++) begin
            d = 2 + int'($urandom % 6);
            b = 8'($urandom);
            wr(A_DIV, d, st);
            wr(A_DATA, {24'($urandom), b}, st);
            check_frame(b, eff(d), "R3 random frame");
        end

        // R6 / R7 receive and consume
        wr(A_DIV, 32'd8, st);
        send_rx(8'hC3, 8);
        rd(A_DATA, rv, rdy); chk(rv == 32'h0000_00C3, "R6 received byte", rv, 32'hC3);
        rd(A_DATA, rv, rdy); chk(rv == 32'hFFFFFFFF, "R7 empty after read", rv, 32'hFFFFFFFF);

        // R10 overwrite
        send_rx(8'h11, 8);
        send_rx(8'h22, 8);
        rd(A_DATA, rv, rdy); chk(rv == 32'h22, "R10 newest byte kept", rv, 32'h22);
        rd(A_DATA, rv, rdy); chk(rv == 32'hFFFFFFFF, "R10 then empty", rv, 32'hFFFFFFFF);

        // R9 short glitch dropped, then a clean frame
        @(negedge clk); rx_i = 1'b0;
        repeat (2) @(negedge clk); rx_i = 1'b1;
        repeat (120) @(negedge clk);
        rd(A_DATA, rv, rdy); chk(rv == 32'hFFFFFFFF, "R9 glitch dropped", rv, 32'hFFFFFFFF);
        send_rx(8'hA9, 8);
        rd(A_DATA, rv, rdy); chk(rv == 32'hA9, "R9 frame after glitch", rv, 32'hA9);

        // R9 random receive at several bit times
        for (int n = 0; n < 6; n++) begin
            d = 8 + int'($urandom % 5);
            b2 = 8'($urandom);
            wr(A_DIV, d, st);
            send_rx(b2, d);
            rd(A_DATA, rv, rdy);
            chk(rv == {24'h0, b2}, "R9 random receive", rv, {24'h0, b2});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule